// File: doc/BRIEF.md
# Banked Internal Data RAM with Stack Pointer

This block is the 128-byte internal data store of a small 8-bit core. Every byte can be reached through a direct 7-bit byte address. The bottom 32 bytes can also be reached as working registers. A 3-bit register index is combined with a 2-bit bank field held in the status word, which gives four banks of eight registers. Sixteen bytes starting at 0x20 can be read, set and cleared one bit at a time through a 7-bit bit address.

The block keeps the core's status word. It holds carry in bit 7, auxiliary carry in bit 6, a user flag in bit 5, bank select in bits 4 (high) and 3 (low), overflow in bit 2 and a spare bit in bit 1. Bit 0 is parity and is derived from the accumulator value the core supplies. An 8-bit stack pointer sits over the same RAM. A push advances the pointer and then stores. A pop returns the byte under the pointer and then moves the pointer back. All reads are combinational. All writes take effect at the rising clock edge, and one write lands per cycle.

Top module: `iram_bankfile`

## Requirements
- R1: While rst_ni is low, and after it is released, every RAM byte reads 0x00, sp_o reads 0x07 and psw_o reads 0x00 with acc_i at 0x00.
- R2: A direct write stores dir_wdata_i at dir_addr_i (0x00 to 0x7F) on the clock edge, and dir_rdata_o shows the byte at dir_addr_i combinationally.
- R3: A register access with index i reaches RAM byte bank*8 + i, where bank = {psw bit 4, psw bit 3}. The same byte is visible through the direct port.
- R4: A status-word write loads bits 7 to 1 of psw_wdata_i, and the bank-select bits read back in psw_o bits 4 and 3.
- R5: psw_o bit 0 is 1 exactly when acc_i has an odd number of ones, so that acc_i and the parity bit together hold an even count. A status-word write never changes bit 0.
- R6: A push adds one to sp_o and stores stk_wdata_i at the new pointer value in the same edge.
- R7: stk_rdata_o shows the byte at the current pointer, and a pop subtracts one from sp_o.
- R8: Bit address b selects byte 0x20 + b[6:3], bit b[2:0]. bit_o reads that bit, bit_set_i sets it and bit_clr_i clears it. When both are high, set wins.
- R9: Only one write happens per cycle. The priority is push first, then register write, then direct write, then bit set or clear, and the losing writes are dropped. A push with a simultaneous pop acts as a push alone.
- R10: The stack uses only the low 7 bits of sp_o as the RAM address, so a push from 0x7F moves sp_o to 0x80 and stores at byte 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_addr_i | input | 7 | Direct byte address |
| dir_we_i | input | 1 | Direct write enable |
| dir_wdata_i | input | 8 | Direct write data |
| dir_rdata_o | output | 8 | Byte at dir_addr_i |
| reg_idx_i | input | 3 | Register index within the active bank |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register at reg_idx_i in the active bank |
| bit_addr_i | input | 7 | Bit address into bytes 0x20 to 0x2F |
| bit_set_i | input | 1 | Set the addressed bit |
| bit_clr_i | input | 1 | Clear the addressed bit |
| bit_o | output | 1 | Value of the addressed bit |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| stk_wdata_i | input | 8 | Data to push |
| stk_rdata_o | output | 8 | Byte at the stack pointer |
| sp_o | output | 8 | Stack pointer |
| psw_we_i | input | 1 | Status word write enable |
| psw_wdata_i | input | 8 | Status word write data |
| acc_i | input | 8 | Accumulator value for the parity bit |
| psw_o | output | 8 | Status word |

## Verification
On every cycle, the assertions check that the stack pointer moves by exactly one on a push or a pop and holds otherwise, and that every granted write lands at its address. They also check that the status word loads or holds as commanded, that the parity bit keeps the combined count even, and that a push always takes the write port. The bench scenarios are the only evidence of the address arithmetic: bank and index folding into a RAM byte, bit-address folding into bytes 0x20 to 0x2F, and the wrap of the stack address at 0x7F. The same holds for writes that are dropped because they lost on priority, and for reset clearing the array.

// File: rtl/iram_pkg.sv
package iram_pkg;
  // status word bit positions
  localparam int unsigned PSW_CY  = 7;
  localparam int unsigned PSW_AC  = 6;
  localparam int unsigned PSW_F0  = 5;
  localparam int unsigned PSW_BK1 = 4;
  localparam int unsigned PSW_BK0 = 3;
  localparam int unsigned PSW_OV  = 2;
  localparam int unsigned PSW_RSV = 1;
  localparam int unsigned PSW_PAR = 0;

  // read ports of the array
  localparam int unsigned RP_DIR = 0;
  localparam int unsigned RP_REG = 1;
  localparam int unsigned RP_STK = 2;
  localparam int unsigned RP_BIT = 3;
  localparam int unsigned RP_NUM = 4;

  typedef enum logic [2:0] {
    WSRC_NONE,
    WSRC_PUSH,
    WSRC_REG,
    WSRC_DIR,
    WSRC_BIT
  } wsrc_e;
endpackage

// File: rtl/iram_array.sv
module iram_array #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RD_N   = 4,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              waddr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [RD_N-1:0][ADDR_W-1:0]    raddr_i,
  output logic [RD_N-1:0][DATA_W-1:0]    rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < RD_N; p++) begin : g_rd
    assign rdata_o[p] = mem_q[raddr_i[p]];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i)); // R2
endmodule

// File: rtl/iram_status.sv
module iram_status
  import iram_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic [DATA_W-1:0] psw_o,
  output logic [1:0]        bank_o
);
  logic [DATA_W-1:1] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   flags_q <= '0;
    else if (we_i) flags_q <= wdata_i[DATA_W-1:1];
  end

  assign psw_o  = {flags_q, ^acc_i};
  assign bank_o = {flags_q[PSW_BK1], flags_q[PSW_BK0]};

  AST_PSW_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> psw_o[DATA_W-1:1] == $past(wdata_i[DATA_W-1:1])); // R4
  AST_PSW_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> psw_o[DATA_W-1:1] == $past(psw_o[DATA_W-1:1])); // R4
  AST_PARITY_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones({acc_i, psw_o[PSW_PAR]}) & 1) == 0); // R5
endmodule

// File: rtl/iram_stack.sv
module iram_stack #(
  parameter int unsigned SP_W     = 8,
  parameter int unsigned ADDR_W   = 7,
  parameter logic [SP_W-1:0] SP_RST = 8'h07
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  output logic [SP_W-1:0]   sp_o,
  output logic [ADDR_W-1:0] top_addr_o,
  output logic [ADDR_W-1:0] next_addr_o
);
  logic [SP_W-1:0] sp_q, sp_inc;

  assign sp_inc = sp_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= SP_RST;
    else if (push_i) sp_q <= sp_inc;
    else if (pop_i)  sp_q <= sp_q - 1'b1;
  end

  assign sp_o        = sp_q;
  assign top_addr_o  = sp_q[ADDR_W-1:0];
  assign next_addr_o = sp_inc[ADDR_W-1:0];

  AST_SP_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> sp_o == SP_W'($past(sp_o) + 1)); // R6
  AST_SP_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> sp_o == SP_W'($past(sp_o) - 1)); // R7
  AST_SP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pop_i && !push_i) |=> $stable(sp_o)); // R7
endmodule

// File: rtl/iram_bankfile.sv
module iram_bankfile
  import iram_pkg::*;
#(
  parameter int unsigned DEPTH     = 128,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned SP_W      = 8,
  parameter int unsigned REG_IDX_W = 3,
  parameter int unsigned BIT_BASE  = 32,
  parameter int unsigned BIT_BYTES = 16,
  parameter logic [SP_W-1:0] SP_RST = 8'h07,
  localparam int unsigned ADDR_W   = $clog2(DEPTH),
  localparam int unsigned BSEL_W   = $clog2(DATA_W),
  localparam int unsigned BIT_AW   = $clog2(BIT_BYTES * DATA_W)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    dir_addr_i,
  input  logic                 dir_we_i,
  input  logic [DATA_W-1:0]    dir_wdata_i,
  output logic [DATA_W-1:0]    dir_rdata_o,
  input  logic [REG_IDX_W-1:0] reg_idx_i,
  input  logic                 reg_we_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  input  logic [BIT_AW-1:0]    bit_addr_i,
  input  logic                 bit_set_i,
  input  logic                 bit_clr_i,
  output logic                 bit_o,
  input  logic                 push_i,
  input  logic                 pop_i,
  input  logic [DATA_W-1:0]    stk_wdata_i,
  output logic [DATA_W-1:0]    stk_rdata_o,
  output logic [SP_W-1:0]      sp_o,
  input  logic                 psw_we_i,
  input  logic [DATA_W-1:0]    psw_wdata_i,
  input  logic [DATA_W-1:0]    acc_i,
  output logic [DATA_W-1:0]    psw_o
);
  logic [1:0]                       bank;
  logic [ADDR_W-1:0]                stk_top, stk_next, reg_addr, bit_byte_addr;
  logic [RP_NUM-1:0][ADDR_W-1:0]    raddr;
  logic [RP_NUM-1:0][DATA_W-1:0]    rdata;
  logic [DATA_W-1:0]                bit_mask, bit_byte_new;
  wsrc_e                            wsrc;
  logic                             arr_we;
  logic [ADDR_W-1:0]                arr_waddr;
  logic [DATA_W-1:0]                arr_wdata;

  iram_status #(.DATA_W(DATA_W)) u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (psw_we_i),
    .wdata_i (psw_wdata_i),
    .acc_i   (acc_i),
    .psw_o   (psw_o),
    .bank_o  (bank)
  );

  iram_stack #(.SP_W(SP_W), .ADDR_W(ADDR_W), .SP_RST(SP_RST)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .sp_o        (sp_o),
    .top_addr_o  (stk_top),
    .next_addr_o (stk_next)
  );

  // bank folds above the index
  assign reg_addr      = ADDR_W'({bank, reg_idx_i});
  assign bit_byte_addr = ADDR_W'(BIT_BASE) + ADDR_W'(bit_addr_i[BIT_AW-1:BSEL_W]);

  assign raddr[RP_DIR] = dir_addr_i;
  assign raddr[RP_REG] = reg_addr;
  assign raddr[RP_STK] = stk_top;
  assign raddr[RP_BIT] = bit_byte_addr;

  iram_array #(.DEPTH(DEPTH), .DATA_W(DATA_W), .RD_N(RP_NUM)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (arr_we),
    .waddr_i (arr_waddr),
    .wdata_i (arr_wdata),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  assign dir_rdata_o = rdata[RP_DIR];
  assign reg_rdata_o = rdata[RP_REG];
  assign stk_rdata_o = rdata[RP_STK];

  // bit read-modify-write; set wins over clear
  assign bit_mask     = DATA_W'(1) << bit_addr_i[BSEL_W-1:0];
  assign bit_byte_new = bit_set_i ? (rdata[RP_BIT] | bit_mask)
                                  : (rdata[RP_BIT] & ~bit_mask);
  assign bit_o        = rdata[RP_BIT][bit_addr_i[BSEL_W-1:0]];

  // single write port, fixed priority
  always_comb begin
    if (push_i)                      wsrc = WSRC_PUSH;
    else if (reg_we_i)               wsrc = WSRC_REG;
    else if (dir_we_i)               wsrc = WSRC_DIR;
    else if (bit_set_i || bit_clr_i) wsrc = WSRC_BIT;
    else                             wsrc = WSRC_NONE;
  end

  always_comb begin
    arr_we    = 1'b1;
    arr_waddr = '0;
    arr_wdata = '0;
    unique case (wsrc)
      WSRC_PUSH: begin arr_waddr = stk_next;      arr_wdata = stk_wdata_i;  end
      WSRC_REG:  begin arr_waddr = reg_addr;      arr_wdata = reg_wdata_i;  end
      WSRC_DIR:  begin arr_waddr = dir_addr_i;    arr_wdata = dir_wdata_i;  end
      WSRC_BIT:  begin arr_waddr = bit_byte_addr; arr_wdata = bit_byte_new; end
      default:   arr_we = 1'b0;
    endcase
  end

  AST_PUSH_OWNS_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (arr_we && arr_waddr == stk_next && arr_wdata == stk_wdata_i)); // R9
  AST_PUSH_READS_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> stk_rdata_o == $past(stk_wdata_i)); // R6
endmodule

// File: tb/tb_iram_bankfile.sv
module tb_iram_bankfile;
  localparam int CLK_PERIOD = 10;

  localparam logic [7:0] OP_DW = 8'd1;  // direct write
  localparam logic [7:0] OP_DR = 8'd2;  // direct read check
  localparam logic [7:0] OP_RW = 8'd3;  // register write
  localparam logic [7:0] OP_RR = 8'd4;  // register read check
  localparam logic [7:0] OP_PW = 8'd5;  // status write
  localparam logic [7:0] OP_PR = 8'd6;  // status read check
  localparam logic [7:0] OP_PU = 8'd7;  // push
  localparam logic [7:0] OP_PO = 8'd8;  // pop, check data
  localparam logic [7:0] OP_SP = 8'd9;  // pointer check
  localparam logic [7:0] OP_BS = 8'd10; // bit set
  localparam logic [7:0] OP_BC = 8'd11; // bit clear
  localparam logic [7:0] OP_BR = 8'd12; // bit read check

  localparam int NVEC = 37;
  // {op, requirement, addr/index, data/expected}
  localparam logic [31:0] VEC [NVEC] = '{
    {OP_DW, 8'd2, 8'h05, 8'hA5}, {OP_DR, 8'd2, 8'h05, 8'hA5},           // R2
    {OP_DW, 8'd2, 8'h7F, 8'h3C}, {OP_DR, 8'd2, 8'h7F, 8'h3C},           // R2
    {OP_RW, 8'd3, 8'h03, 8'h11}, {OP_DR, 8'd3, 8'h03, 8'h11},           // R3 bank 0
    {OP_PW, 8'd4, 8'h00, 8'h18}, {OP_RW, 8'd3, 8'h03, 8'h22},           // R3 bank 3
    {OP_DR, 8'd3, 8'h1B, 8'h22}, {OP_DR, 8'd3, 8'h03, 8'h11},           // R3
    {OP_PR, 8'd4, 8'h00, 8'h18},                                         // R4
    {OP_PW, 8'd4, 8'h00, 8'h08}, {OP_RR, 8'd3, 8'h03, 8'h00},           // R3 bank 1
    {OP_DW, 8'd3, 8'h0B, 8'h5A}, {OP_RR, 8'd3, 8'h03, 8'h5A},           // R3
    {OP_PU, 8'd6, 8'h00, 8'h77}, {OP_SP, 8'd6, 8'h00, 8'h08},           // R6
    {OP_DR, 8'd6, 8'h08, 8'h77}, {OP_RR, 8'd3, 8'h00, 8'h77},           // R6 R3
    {OP_PU, 8'd6, 8'h00, 8'h88}, {OP_SP, 8'd6, 8'h00, 8'h09},           // R6
    {OP_PO, 8'd7, 8'h00, 8'h88}, {OP_SP, 8'd7, 8'h00, 8'h08},           // R7
    {OP_PO, 8'd7, 8'h00, 8'h77}, {OP_SP, 8'd7, 8'h00, 8'h07},           // R7
    {OP_BS, 8'd8, 8'h0A, 8'h00}, {OP_DR, 8'd8, 8'h21, 8'h04},           // R8
    {OP_BS, 8'd8, 8'h7F, 8'h00}, {OP_DR, 8'd8, 8'h2F, 8'h80},           // R8
    {OP_BR, 8'd8, 8'h7F, 8'h01}, {OP_BR, 8'd8, 8'h7E, 8'h00},           // R8
    {OP_BC, 8'd8, 8'h0A, 8'h00}, {OP_DR, 8'd8, 8'h21, 8'h00},           // R8
    {OP_PW, 8'd4, 8'h00, 8'hFF}, {OP_PR, 8'd5, 8'h00, 8'hFE},           // R5 write skips parity
    {OP_PW, 8'd4, 8'h00, 8'h00}, {OP_PR, 8'd4, 8'h00, 8'h00}            // R4
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] dir_addr = '0;
  logic       dir_we = 1'b0;
  logic [7:0] dir_wdata = '0;
  logic [7:0] dir_rdata;
  logic [2:0] reg_idx = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [6:0] bit_addr = '0;
  logic       bit_set = 1'b0;
  logic       bit_clr = 1'b0;
  logic       bit_val;
  logic       push = 1'b0;
  logic       pop = 1'b0;
  logic [7:0] stk_wdata = '0;
  logic [7:0] stk_rdata;
  logic [7:0] sp;
  logic       psw_we = 1'b0;
  logic [7:0] psw_wdata = '0;
  logic [7:0] acc = '0;
  logic [7:0] psw;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iram_bankfile dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .dir_addr_i(dir_addr), .dir_we_i(dir_we), .dir_wdata_i(dir_wdata), .dir_rdata_o(dir_rdata),
    .reg_idx_i(reg_idx), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .bit_addr_i(bit_addr), .bit_set_i(bit_set), .bit_clr_i(bit_clr), .bit_o(bit_val),
    .push_i(push), .pop_i(pop), .stk_wdata_i(stk_wdata), .stk_rdata_o(stk_rdata), .sp_o(sp),
    .psw_we_i(psw_we), .psw_wdata_i(psw_wdata), .acc_i(acc), .psw_o(psw)
  );

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_strobes();
    dir_we = 0; reg_we = 0; bit_set = 0; bit_clr = 0; push = 0; pop = 0; psw_we = 0;
  endtask

  task automatic run_vec(input logic [31:0] v);
    logic [7:0] op, a, d;
    int req;
    op = v[31:24]; req = int'(v[23:16]); a = v[15:8]; d = v[7:0];
    case (op)
      OP_DW: begin dir_addr = a[6:0]; dir_wdata = d; dir_we = 1; tick(); end
      OP_DR: begin dir_addr = a[6:0]; #1 check(req, dir_rdata, d, "direct read"); end
      OP_RW: begin reg_idx = a[2:0]; reg_wdata = d; reg_we = 1; tick(); end
      OP_RR: begin reg_idx = a[2:0]; #1 check(req, reg_rdata, d, "register read"); end
      OP_PW: begin psw_wdata = d; psw_we = 1; tick(); end
      OP_PR: begin #1 check(req, psw, d, "status word"); end
      OP_PU: begin stk_wdata = d; push = 1; tick(); end
      OP_PO: begin pop = 1; #1 check(req, stk_rdata, d, "pop data"); tick(); end
      OP_SP: begin #1 check(req, sp, d, "stack pointer"); end
      OP_BS: begin bit_addr = a[6:0]; bit_set = 1; tick(); end
      OP_BC: begin bit_addr = a[6:0]; bit_clr = 1; tick(); end
      OP_BR: begin bit_addr = a[6:0]; #1 check(req, {7'd0, bit_val}, d, "bit read"); end
      default: ;
    endcase
    clear_strobes();
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) tick();
    check(1, sp, 8'h07, "sp in reset");
    rst_ni = 1;
    tick();
    check(1, sp, 8'h07, "sp after reset");
    check(1, psw, 8'h00, "psw after reset");
    dir_addr = 7'h05; #1 check(1, dir_rdata, 8'h00, "ram after reset");

    for (int i = 0; i < NVEC; i++) begin
      tick();
      run_vec(VEC[i]);
    end

    // R5: parity follows acc_i
    tick();
    acc = 8'h01; #1 check(5, psw, 8'h01, "parity 01");
    acc = 8'h03; #1 check(5, psw, 8'h00, "parity 03");
    acc = 8'h80; #1 check(5, psw, 8'h01, "parity 80");
    acc = 8'hFF; #1 check(5, psw, 8'h00, "parity FF");
    acc = 8'h00;

    // R9: push beats register and direct writes
    tick();
    push = 1; stk_wdata = 8'h55;
    reg_we = 1; reg_idx = 3'd1; reg_wdata = 8'h33;
    dir_we = 1; dir_addr = 7'h40; dir_wdata = 8'h99;
    tick(); clear_strobes();
    dir_addr = 7'h08; #1 check(9, dir_rdata, 8'h55, "push won");
    dir_addr = 7'h40; #1 check(9, dir_rdata, 8'h00, "direct dropped");
    dir_addr = 7'h01; #1 check(9, dir_rdata, 8'h00, "register dropped");
    check(9, sp, 8'h08, "sp after contested push");
    // R9: push with pop acts as push
    tick();
    push = 1; pop = 1; stk_wdata = 8'h66;
    tick(); clear_strobes();
    #1 check(9, sp, 8'h09, "push+pop pointer");
    check(9, stk_rdata, 8'h66, "push+pop data");
    // R9: register beats direct, direct beats bit
    tick();
    reg_we = 1; reg_idx = 3'd1; reg_wdata = 8'h33;
    dir_we = 1; dir_addr = 7'h01; dir_wdata = 8'h44;
    tick(); clear_strobes();
    dir_addr = 7'h01; #1 check(9, dir_rdata, 8'h33, "register over direct");
    tick();
    dir_we = 1; dir_addr = 7'h22; dir_wdata = 8'hF0;
    bit_set = 1; bit_addr = 7'h10;
    tick(); clear_strobes();
    dir_addr = 7'h22; #1 check(9, dir_rdata, 8'hF0, "direct over bit");
    // R8: set wins over clear
    tick();
    bit_set = 1; bit_clr = 1; bit_addr = 7'h18;
    tick(); clear_strobes();
    dir_addr = 7'h23; #1 check(8, dir_rdata, 8'h01, "set beats clear");

    // R10: pointer wrap of the stack address
    for (int i = 0; i < 200 && sp != 8'h7F; i++) begin
      push = 1; stk_wdata = 8'(i);
      tick();
    end
    push = 1; stk_wdata = 8'hEE;
    tick(); clear_strobes();
    #1 check(10, sp, 8'h80, "sp past 7F");
    dir_addr = 7'h00; #1 check(10, dir_rdata, 8'hEE, "wrapped store");
    pop = 1; #1 check(10, stk_rdata, 8'hEE, "wrapped pop");
    tick(); clear_strobes();
    #1 check(10, sp, 8'h7F, "sp after wrapped pop");

    // R1: reset mid-run
    rst_ni = 0; #1;
    check(1, sp, 8'h07, "sp on reset");
    dir_addr = 7'h05; #1 check(1, dir_rdata, 8'h00, "ram on reset");
    check(1, psw, 8'h00, "psw on reset");
    tick(); rst_ni = 1; tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule